// File: doc/BRIEF.md
# Configurable Multi-Source I/O Port

This block is a bidirectional port of `W` pins (eight by default) for a microcontroller. Software writes a bank of configuration registers through a simple address/strobe interface. The registers set, for each pin on its own, what drives the pin, when the pin's output driver is on, and how the pin's input value is captured.

Each pin has its own four-way output multiplexer. It picks one of four sources: the data-out register bit, a latched address bit, a logic-array macrocell output, or a chip-select line. The output driver turns on when the pin's direction bit is set. It also turns on when an external enable term is asserted and that term has been marked as used for the pin. On the input side, a capture cell hands the pin value to the logic array in one of three ways: as a direct pass-through, as a transparent latch, or as a register that samples on a rising edge. The cell's gate comes either from the address strobe or from a per-pin product-term clock.

A combinational readback multiplexer lets software read any configuration register, the macrocell outputs, the capture cell outputs or the raw pin levels. Tri-state pads are modelled as separate `pin_out`, `pin_oe` and `pin_in` vectors.

Top module: `mio_port`

## Requirements
- R1: After synchronous reset, every configuration register reads 0 and `pin_oe` is all zeros. All pins then drive their data-out bit, capture in direct mode and gate from the address strobe.
- R2: Each configuration address takes `wr_data` on a rising clock edge when `wr_en` is high, and reads back on `rd_data` at the same address. The addresses are: 0 data-out, 1 direction, 2 source-select bit 0, 3 source-select bit 1, 4 capture-mode bit 0, 5 capture-mode bit 1, 6 gate select, 7 enable-term-used mask. Bit i of each register belongs to pin i.
- R3: Pin i drives the source given by the code {reg3[i], reg2[i]}: 0 data-out bit, 1 `addr_lat[i]`, 2 `mcell_out[i]`, 3 `cs_in[i]`.
- R4: `pin_oe[i]` equals direction[i] OR (`pt_oe[i]` AND enable-used[i]). When the enable-used bit is 0, the direction bit alone sets the driver.
- R5: Address 8 reads `mcell_out`, address 9 reads `cap_out`, address 10 reads `pin_in`, and addresses 11 to 15 read zero. Writes to addresses 8 to 15 change no configuration register.
- R6: In capture code 0 or 3, where the code is {reg5[i], reg4[i]}, `cap_out[i]` equals `pin_in[i]` in the same cycle.
- R7: In capture code 1 (latch), `cap_out[i]` follows `pin_in[i]` while the pin's gate is high. While the gate is low, it holds the value the pin had at the last rising clock edge at which the gate was high.
- R8: In capture code 2 (edge register), `cap_out[i]` takes `pin_in[i]` at a rising clock edge where the gate is high and was low at the previous edge. At every other edge it holds its value.
- R9: Pin i's gate is `as_strobe` when gate-select[i] is 0, and `pt_clk[i]` when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address for write and readback |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Write data |
| rd_data | output | W | Readback data (combinational) |
| addr_lat | input | W | Latched address bits, output source 1 |
| mcell_out | input | W | Logic macrocell outputs, output source 2 |
| cs_in | input | W | Chip-select lines, output source 3 |
| pt_oe | input | W | External output-enable product terms |
| pt_clk | input | W | Per-pin product-term capture gates |
| as_strobe | input | 1 | Address strobe, shared capture gate |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Pad output values |
| pin_oe | output | W | Pad output driver enables |
| cap_out | output | W | Capture cell outputs to the logic array |

## Verification
The assertions take for granted that every input is at a known level at each rising edge once reset is released. They also assume that reset is held through the first edge, so the configuration bank and the gate history start from zero. The stimulus changes every input only at falling edges. It holds the strobe and the product-term clocks low while the capture-mode registers are rewritten, so no capture happens in a half-written mode. Random vectors for the source, enable and pin inputs are always fully defined values.

// File: rtl/mio_pkg.sv
package mio_pkg;

    localparam int ADDR_W  = 4;
    localparam int NUM_CFG = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT  = 4'd0,
        RA_DIR   = 4'd1,
        RA_SRC0  = 4'd2,
        RA_SRC1  = 4'd3,
        RA_MODE0 = 4'd4,
        RA_MODE1 = 4'd5,
        RA_GSEL  = 4'd6,
        RA_OEUSE = 4'd7,
        RA_MCELL = 4'd8,
        RA_CAP   = 4'd9,
        RA_PIN   = 4'd10
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_DOUT  = 2'd0,
        SRC_ADDR  = 2'd1,
        SRC_MCELL = 2'd2,
        SRC_CS    = 2'd3
    } out_src_e;

    typedef enum logic [1:0] {
        CAP_DIRECT = 2'd0,
        CAP_LATCH  = 2'd1,
        CAP_EDGE   = 2'd2,
        CAP_ALT    = 2'd3
    } cap_mode_e;

    typedef struct packed {
        logic      dout;
        logic      dir;
        out_src_e  src;
        cap_mode_e mode;
        logic      gsel;
        logic      oe_use;
    } pin_cfg_t;

    function automatic logic pick_source(out_src_e s, logic d, logic a, logic m, logic c);
        case (s)
            SRC_DOUT:  return d;
            SRC_ADDR:  return a;
            SRC_MCELL: return m;
            default:   return c;
        endcase
    endfunction

endpackage

// File: rtl/mio_cfg_bank.sv
module mio_cfg_bank
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [W-1:0]                  wr_data,
    output logic [NUM_CFG-1:0][W-1:0]     bank
);
    localparam int SEL_W = $clog2(NUM_CFG);

    logic [NUM_CFG-1:0][W-1:0] bank_q;
    logic                      hit;

    assign hit  = wr_en && (wr_addr < ADDR_W'(NUM_CFG));
    assign bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (hit) begin
            bank_q[wr_addr[SEL_W-1:0]] <= wr_data;
        end
    end
endmodule

// File: rtl/mio_rd_mux.sv
module mio_rd_mux
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_CFG-1:0][W-1:0]     bank,
    input  logic [W-1:0]                  mcell_out,
    input  logic [W-1:0]                  cap_out,
    input  logic [W-1:0]                  pin_in,
    output logic [W-1:0]                  rd_data
);
    localparam int SEL_W = $clog2(NUM_CFG);

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(NUM_CFG)) begin
            rd_data = bank[rd_addr[SEL_W-1:0]];
        end else begin
            case (rd_addr)
                RA_MCELL: rd_data = mcell_out;
                RA_CAP:   rd_data = cap_out;
                RA_PIN:   rd_data = pin_in;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mio_pin_cell.sv
module mio_pin_cell
    import mio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     addr_bit,
    input  logic     mcell_bit,
    input  logic     cs_bit,
    input  logic     pt_oe_bit,
    input  logic     pt_clk_bit,
    input  logic     as_strobe,
    input  logic     pin_in_bit,
    output logic     pin_out_bit,
    output logic     pin_oe_bit,
    output logic     cap_bit
);
    logic gate;
    logic gate_q;
    logic held_q;
    logic load;

    assign gate        = cfg.gsel ? pt_clk_bit : as_strobe;
    assign pin_out_bit = pick_source(cfg.src, cfg.dout, addr_bit, mcell_bit, cs_bit);
    assign pin_oe_bit  = cfg.dir | (pt_oe_bit & cfg.oe_use);

    always_comb begin
        case (cfg.mode)
            CAP_LATCH: load = gate;
            CAP_EDGE:  load = gate & ~gate_q;
            default:   load = 1'b0;
        endcase
    end

    always_comb begin
        case (cfg.mode)
            CAP_LATCH: cap_bit = gate ? pin_in_bit : held_q;
            CAP_EDGE:  cap_bit = held_q;
            default:   cap_bit = pin_in_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (load) begin
                held_q <= pin_in_bit;
            end
        end
    end
endmodule

// File: rtl/mio_port.sv
module mio_port
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      addr_lat,
    input  logic [W-1:0]      mcell_out,
    input  logic [W-1:0]      cs_in,
    input  logic [W-1:0]      pt_oe,
    input  logic [W-1:0]      pt_clk,
    input  logic              as_strobe,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      cap_out
);
    logic [NUM_CFG-1:0][W-1:0] bank;
    logic [W-1:0] dout_v, dir_v, src0_v, src1_v, mode0_v, mode1_v, gsel_v, oeuse_v;

    assign dout_v  = bank[RA_DOUT];
    assign dir_v   = bank[RA_DIR];
    assign src0_v  = bank[RA_SRC0];
    assign src1_v  = bank[RA_SRC1];
    assign mode0_v = bank[RA_MODE0];
    assign mode1_v = bank[RA_MODE1];
    assign gsel_v  = bank[RA_GSEL];
    assign oeuse_v = bank[RA_OEUSE];

    mio_cfg_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .bank    (bank)
    );

    mio_rd_mux #(.W(W)) u_rd (
        .rd_addr   (reg_addr),
        .bank      (bank),
        .mcell_out (mcell_out),
        .cap_out   (cap_out),
        .pin_in    (pin_in),
        .rd_data   (rd_data)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{
            dout:   dout_v[i],
            dir:    dir_v[i],
            src:    out_src_e'({src1_v[i], src0_v[i]}),
            mode:   cap_mode_e'({mode1_v[i], mode0_v[i]}),
            gsel:   gsel_v[i],
            oe_use: oeuse_v[i]
        };

        mio_pin_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .cfg         (cfg),
            .addr_bit    (addr_lat[i]),
            .mcell_bit   (mcell_out[i]),
            .cs_bit      (cs_in[i]),
            .pt_oe_bit   (pt_oe[i]),
            .pt_clk_bit  (pt_clk[i]),
            .as_strobe   (as_strobe),
            .pin_in_bit  (pin_in[i]),
            .pin_out_bit (pin_out[i]),
            .pin_oe_bit  (pin_oe[i]),
            .cap_bit     (cap_out[i])
        );
    end
endmodule

// File: rtl/mio_port_chk.sv
module mio_port_chk
    import mio_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic [W-1:0]      wr_data,
    input logic [W-1:0]      rd_data,
    input logic [W-1:0]      pin_in,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      cap_out,
    input logic [W-1:0]      dout_v,
    input logic [W-1:0]      src0_v,
    input logic [W-1:0]      src1_v,
    input logic [W-1:0]      mode0_v,
    input logic [W-1:0]      mode1_v
);
    // R1
    reset_oe_chk: assert property (@(posedge clk) rst |=> (pin_oe == '0));

    // R2
    dout_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == RA_DOUT) |=> (dout_v == $past(wr_data)));

    // R4
    dir_forces_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == RA_DIR) |=> ((pin_oe & $past(wr_data)) == $past(wr_data)));

    // R3
    dout_source_chk: assert property (@(posedge clk) disable iff (rst)
        ((~src0_v & ~src1_v & (pin_out ^ dout_v)) == '0));

    // R6
    direct_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ((~(mode0_v ^ mode1_v) & (cap_out ^ pin_in)) == '0));

    // R5
    pin_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_PIN) |-> (rd_data == pin_in));
endmodule

bind mio_port mio_port_chk #(.W(W)) u_mio_port_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .cap_out  (cap_out),
    .dout_v   (dout_v),
    .src0_v   (src0_v),
    .src1_v   (src1_v),
    .mode0_v  (mode0_v),
    .mode1_v  (mode1_v)
);

// File: tb/mio_port_bench.sv
module mio_port_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   reg_addr;
    logic         wr_en;
    logic [W-1:0] wr_data, rd_data;
    logic [W-1:0] addr_lat, mcell_out, cs_in, pt_oe, pt_clk, pin_in;
    logic         as_strobe;
    logic [W-1:0] pin_out, pin_oe, cap_out;

    int n_vec  = 0;
    int n_fail = 0;
    logic [W-1:0] shadow [8];

    always #4 clk = ~clk;

    mio_port #(.W(W)) u_mio_port (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .addr_lat(addr_lat), .mcell_out(mcell_out), .cs_in(cs_in),
        .pt_oe(pt_oe), .pt_clk(pt_clk), .as_strobe(as_strobe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .cap_out(cap_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd8) shadow[a[2:0]] = d;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [W-1:0] exp_out(input logic [W-1:0] s0, input logic [W-1:0] s1,
                                             input logic [W-1:0] d, input logic [W-1:0] a,
                                             input logic [W-1:0] m, input logic [W-1:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            case ({s1[i], s0[i]})
                2'd0: r[i] = d[i];
                2'd1: r[i] = a[i];
                2'd2: r[i] = m[i];
                default: r[i] = c[i];
            endcase
        end
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] v, d, a, m, c, pe;
        rst = 1'b1; reg_addr = '0; wr_en = 1'b0; wr_data = '0;
        addr_lat = 8'h3C; mcell_out = 8'hA5; cs_in = 8'h0F; pt_oe = 8'hFF;
        pt_clk = '0; as_strobe = 1'b0; pin_in = 8'h5A;
        for (int k = 0; k < 8; k++) shadow[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), v);
            check("R1 reg reset", v, '0);
        end
        check("R1 oe reset", pin_oe, '0);
        check("R1 out is dout", pin_out, '0);
        check("R1 direct capture", cap_out, pin_in);

        // R2 write/readback over several patterns
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 8; k++) begin
                d = (p == 0) ? 8'hA5 : (p == 1) ? 8'h5A : (p == 2) ? 8'hFF : 8'(k * 37 + p * 11);
                wr(4'(k), d);
                rd(4'(k), v);
                check("R2 readback", v, d);
            end
        end
        for (int k = 0; k < 8; k++) wr(4'(k), '0);

        // R3 uniform source codes
        for (int s = 0; s < 4; s++) begin
            wr(4'd2, {W{s[0]}});
            wr(4'd3, {W{s[1]}});
            for (int n = 0; n < 8; n++) begin
                d = 8'($urandom); a = 8'($urandom); m = 8'($urandom); c = 8'($urandom);
                wr(4'd0, d);
                addr_lat = a; mcell_out = m; cs_in = c;
                #1;
                check("R3 source sweep", pin_out, exp_out({W{s[0]}}, {W{s[1]}}, d, a, m, c));
            end
        end
        // R3 mixed per-pin codes
        wr(4'd2, 8'hAA); wr(4'd3, 8'hCC);
        for (int n = 0; n < 8; n++) begin
            a = 8'($urandom); m = 8'($urandom); c = 8'($urandom);
            addr_lat = a; mcell_out = m; cs_in = c;
            #1;
            check("R3 mixed codes", pin_out, exp_out(8'hAA, 8'hCC, shadow[0], a, m, c));
        end

        // R4 output enable
        for (int n = 0; n < 24; n++) begin
            d = 8'($urandom); c = 8'($urandom); pe = 8'($urandom);
            wr(4'd1, d);
            wr(4'd7, c);
            pt_oe = pe;
            #1;
            check("R4 oe combine", pin_oe, d | (pe & c));
        end
        wr(4'd7, 8'h00); pt_oe = 8'hFF; wr(4'd1, 8'h81);
        #1;
        check("R4 unused term ignored", pin_oe, 8'h81);

        // R5 readback of non-register sources and unmapped addresses
        mcell_out = 8'h96; pin_in = 8'h3E;
        rd(4'd8, v);  check("R5 mcell read", v, 8'h96);
        rd(4'd9, v);  check("R5 cap read", v, cap_out);
        rd(4'd10, v); check("R5 pin read", v, 8'h3E);
        for (int k = 11; k < 16; k++) begin
            rd(4'(k), v); check("R5 unmapped zero", v, '0);
        end
        for (int k = 8; k < 16; k++) wr(4'(k), 8'hFF);
        for (int k = 0; k < 8; k++) begin
            rd(4'(k), v); check("R5 write ignored", v, shadow[k]);
        end

        // R6 direct modes 0 and 3
        as_strobe = 1'b0; pt_clk = '0;
        wr(4'd6, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h00);
        for (int n = 0; n < 16; n++) begin
            pin_in = 8'(n * 17 + 3); #1;
            check("R6 direct code0", cap_out, 8'(n * 17 + 3));
        end
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
        for (int n = 0; n < 16; n++) begin
            pin_in = 8'(n * 29 + 1); #1;
            check("R6 direct code3", cap_out, 8'(n * 29 + 1));
        end

        // R7 latch mode
        wr(4'd5, 8'h00);
        @(negedge clk);
        as_strobe = 1'b1; pin_in = 8'hC3; #1;
        check("R7 latch transparent", cap_out, 8'hC3);
        @(negedge clk);
        as_strobe = 1'b0; pin_in = 8'h18; #1;
        check("R7 latch hold", cap_out, 8'hC3);
        @(negedge clk);
        pin_in = 8'h77; #1;
        check("R7 latch hold 2", cap_out, 8'hC3);

        // R8 edge register mode
        wr(4'd4, 8'h00); wr(4'd5, 8'hFF);
        @(negedge clk);
        as_strobe = 1'b1; pin_in = 8'h4D; #1;
        check("R8 before edge", cap_out, 8'hC3);
        @(negedge clk); #1;
        check("R8 capture on rise", cap_out, 8'h4D);
        pin_in = 8'hB2;
        @(negedge clk); #1;
        check("R8 no capture while high", cap_out, 8'h4D);
        as_strobe = 1'b0;
        @(negedge clk); #1;
        check("R8 no capture on fall", cap_out, 8'h4D);
        as_strobe = 1'b1; pin_in = 8'hE1;
        @(negedge clk); #1;
        check("R8 second rise", cap_out, 8'hE1);
        as_strobe = 1'b0;

        // R9 gate select: low nibble from pt_clk, high nibble from strobe, latch mode
        wr(4'd5, 8'h00); wr(4'd4, 8'hFF); wr(4'd6, 8'h0F);
        pin_in = 8'h00; as_strobe = 1'b1; pt_clk = 8'hFF;
        @(negedge clk);
        as_strobe = 1'b1; pt_clk = 8'h00; pin_in = 8'hFF; #1;
        check("R9 strobe gates high nibble", cap_out, 8'hF0);
        @(negedge clk);
        as_strobe = 1'b0; pt_clk = 8'hFF; pin_in = 8'h3C; #1;
        check("R9 pt_clk gates low nibble", cap_out, 8'hFC);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule